// File: doc/BRIEF.md
# APB Requester Bridge

This block turns single transfer commands into APB bus transfers. A command carries an address, write data and a direction bit, and it is handed over on a valid/ready handshake. The bridge then runs the bus through a one-cycle setup phase and an access phase. The access phase lasts as long as the completer keeps PREADY low, so a slow completer can add any number of wait states.

When the transfer completes, the bridge captures the read data and the error flag from that completion edge only. It then reports them on a response port that is valid for exactly one cycle. Only one transfer is in flight at a time. The bridge can still accept the next command on the completion cycle, so back-to-back traffic goes from completion straight into the next setup with no idle cycle between them.

Top module: `apb_req_bridge`

## Requirements
- R1: Reset is asynchronous and active low. While reset is held, and in the first cycle after it, psel, penable and rsp_valid are low and cmd_ready is high.
- R2: In the idle state with cmd_valid low, the bus stays idle (psel and penable low), and cmd_ready stays high.
- R3: In the cycle after a command is accepted, the bus is in setup: psel is 1 and penable is 0. paddr and pwrite equal the command. pwdata equals the command data for a write (cmd_write=1) and zero for a read (cmd_write=0). Setup lasts exactly one cycle, whatever value pready has.
- R4: The cycle after setup is access: psel and penable are both 1, and paddr, pwrite and pwdata hold their setup values.
- R5: Each rising edge in access with pready low keeps the bus in access for another cycle. cmd_ready is low during such a wait cycle.
- R6: A transfer completes on the edge where psel, penable and pready are all high. In the next cycle rsp_valid is 1 and rsp_err equals pslverr from that edge. For a read, rsp_rdata equals prdata from that edge. Values of prdata and pslverr in setup or wait cycles have no effect on the response.
- R7: A write response carries rsp_rdata equal to zero, even when the completer drives nonzero prdata.
- R8: cmd_ready is high on the completion cycle and low in setup. A command presented then is accepted, and the next cycle is its setup (no idle cycle between the two transfers).
- R9: When no command is pending at completion, the next cycle is idle: psel and penable are low.
- R10: rsp_valid is high for exactly one cycle per completed transfer and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The bridge takes the offered command on this edge |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| cmd_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | One-cycle strobe: the response is valid |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rsp_err | output | 1 | Error flag from the completer |
| psel | output | 1 | Bus select |
| penable | output | 1 | Access phase marker |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pready | input | 1 | Completer ready, ends access |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error flag |

## Verification
Two things can fall in the same clock edge: the completion of one transfer, with its response capture, and the acceptance of the next command. The bench provokes this by keeping a command offered through every wait cycle of a transfer. Across those cycles cmd_ready must stay low, and it must rise only on the completion cycle. In the following cycle the bench expects the old transfer's response and the new transfer's setup side by side, each judged against values computed from the two command indices. A sweep over direction, error flag, zero to three wait states and chained versus gapped transfers covers every ordering. During waits the completer drives junk read data and a raised error flag, to show that only the completion edge is captured.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } apb_phase_e;
endpackage

// File: rtl/apb_req_seq.sv
module apb_req_seq
  import apb_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       pready,
  output apb_phase_e phase_q,
  output logic       cmd_ready,
  output logic       accept,
  output logic       done
);
  apb_phase_e phase_d;

  always_comb begin
    done      = (phase_q == PH_ACCESS) && pready;
    cmd_ready = (phase_q == PH_IDLE) || done;
    accept    = cmd_valid && cmd_ready;
    case (phase_q)
      PH_IDLE:   phase_d = accept ? PH_SETUP : PH_IDLE;
      PH_SETUP:  phase_d = PH_ACCESS;
      PH_ACCESS: phase_d = done ? (accept ? PH_SETUP : PH_IDLE) : PH_ACCESS;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/apb_req_launch.sv
module apb_req_launch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_write,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata
);
  localparam logic [DATA_W-1:0] ZERO_W = '0;

  logic [DATA_W-1:0] wdata_d;

  always_comb wdata_d = cmd_write ? cmd_wdata : ZERO_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr  <= '0;
      pwrite <= 1'b0;
      pwdata <= '0;
    end else if (load) begin
      paddr  <= cmd_addr;
      pwrite <= cmd_write;
      pwdata <= wdata_d;
    end
  end
endmodule

// File: rtl/apb_req_rsp.sv
module apb_req_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              pwrite,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam logic [DATA_W-1:0] ZERO_R = '0;

  logic [DATA_W-1:0] rdata_d;

  always_comb rdata_d = pwrite ? ZERO_R : prdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (done) begin
      rsp_rdata <= rdata_d;
      rsp_err   <= pslverr;
    end
  end
endmodule

// File: rtl/apb_req_bridge.sv
module apb_req_bridge
  import apb_req_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_write,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  apb_phase_e phase_q;
  logic       accept;
  logic       done;

  apb_req_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .pready    (pready),
    .phase_q   (phase_q),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .done      (done)
  );

  apb_req_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) launch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_write (cmd_write),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata)
  );

  apb_req_rsp #(.DATA_W(DATA_W)) rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .pwrite    (pwrite),
    .prdata    (prdata),
    .pslverr   (pslverr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  always_comb begin
    psel    = (phase_q != PH_IDLE);
    penable = (phase_q == PH_ACCESS);
  end
endmodule

// File: rtl/apb_req_chk.sv
module apb_req_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              psel,
  input logic              penable,
  input logic              pready,
  input logic [ADDR_W-1:0] paddr,
  input logic              pwrite,
  input logic [DATA_W-1:0] pwdata,
  input logic              rsp_valid
);
  p_enable_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> !penable);

  p_setup_then_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  p_read_zero_wdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite) |-> (pwdata == '0));

  p_access_holds_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  p_no_accept_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |-> !cmd_ready);

  p_rsp_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready) |=> rsp_valid);

  p_ready_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!psel || (penable && pready)));

  p_chain_to_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && cmd_valid) |=> (psel && !penable));

  p_done_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && !cmd_valid) |=> !psel);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(psel && penable && pready));
endmodule

bind apb_req_bridge apb_req_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .psel      (psel),
  .penable   (penable),
  .pready    (pready),
  .paddr     (paddr),
  .pwrite    (pwrite),
  .pwdata    (pwdata),
  .rsp_valid (rsp_valid)
);

// File: tb/apb_req_bridge_tb_top.sv
module apb_req_bridge_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_write;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic          psel;
  logic          penable;
  logic [AW-1:0] paddr;
  logic          pwrite;
  logic [DW-1:0] pwdata;
  logic          pready;
  logic [DW-1:0] prdata;
  logic          pslverr;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  apb_req_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_write (cmd_write),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .psel      (psel),
    .penable   (penable),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .pready    (pready),
    .prdata    (prdata),
    .pslverr   (pslverr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] addr_of(input int k);
    return AW'(16'h0400 + k * 19);
  endfunction

  function automatic logic [DW-1:0] data_of(input int k);
    return 32'h0BAD_F00D ^ DW'(k * 32'h0102_0304);
  endfunction

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic present(input int k);
    cmd_valid = 1'b1;
    cmd_addr  = addr_of(k);
    cmd_wdata = data_of(k);
    cmd_write = k[0];
  endtask

  // Entered at the negedge of the setup cycle of transfer k.
  task automatic run_xfer(input int k, input bit chained_in, output bit chain);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [DW-1:0] rd;
    bit w;
    bit err;
    int waits;
    a     = addr_of(k);
    d     = data_of(k);
    w     = k[0];
    err   = k[1];
    waits = k[3:2];
    chain = k[4] && (k < 31);
    rd    = rd_model(a);

    cmd_valid = 1'b0;
    pready    = 1'b1;          // completer ready during setup: must not shorten it
    prdata    = 32'hFACE_0000;
    pslverr   = 1'b1;
    if (chain) present(k + 1);
    #1;
    check(psel && !penable, "R3", "setup phase", {30'd0, psel, penable}, 32'h2);
    check(paddr == a, "R3", "setup paddr", DW'(paddr), DW'(a));
    check(pwrite == w, "R3", "setup pwrite", DW'(pwrite), DW'(w));
    check(pwdata == (w ? d : '0), "R3", "setup pwdata", pwdata, w ? d : '0);
    check(!cmd_ready, "R8", "ready low in setup", DW'(cmd_ready), 0);
    if (!chained_in)
      check(!rsp_valid, "R10", "no response in setup", DW'(rsp_valid), 0);

    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      if (i < waits) begin
        pready  = 1'b0;
        prdata  = 32'hDEAD_0000 | DW'(i);
        pslverr = 1'b1;
      end else begin
        pready  = 1'b1;
        prdata  = rd;
        pslverr = err;
      end
      #1;
      check(psel && penable, "R4", "access phase", {30'd0, psel, penable}, 32'h3);
      check(paddr == a && pwrite == w && pwdata == (w ? d : '0), "R4",
            "access control held", DW'(paddr), DW'(a));
      if (i == 0)
        check(!rsp_valid, "R10", "response dropped", DW'(rsp_valid), 0);
      if (i < waits)
        check(!cmd_ready, "R5", "ready low in wait", DW'(cmd_ready), 0);
      else
        check(cmd_ready, "R8", "ready on completion", DW'(cmd_ready), 1);
    end

    @(negedge clk);
    pready  = 1'b0;
    prdata  = 32'hBEEF_0000;
    pslverr = 1'b1;
    #1;
    check(rsp_valid, "R6", "response valid", DW'(rsp_valid), 1);
    check(rsp_err == err, "R6", "response error", DW'(rsp_err), DW'(err));
    if (w) check(rsp_rdata == '0, "R7", "write rdata zero", rsp_rdata, '0);
    else   check(rsp_rdata == rd, "R6", "read data", rsp_rdata, rd);
    if (chain) begin
      check(psel && !penable && paddr == addr_of(k + 1), "R8",
            "chained setup", DW'(paddr), DW'(addr_of(k + 1)));
    end else begin
      check(!psel && !penable, "R9", "idle after done", {30'd0, psel, penable}, 0);
      check(cmd_ready, "R2", "ready in idle", DW'(cmd_ready), 1);
    end
  endtask

  initial begin
    bit chained;
    bit chain_out;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_addr  = '0;
    cmd_wdata = '0;
    cmd_write = 1'b0;
    pready    = 1'b0;
    prdata    = '0;
    pslverr   = 1'b0;
    repeat (3) @(negedge clk);
    check(!psel && !penable && !rsp_valid, "R1", "outputs in reset",
          {29'd0, psel, penable, rsp_valid}, 0);
    check(cmd_ready, "R1", "ready in reset", DW'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!psel && !penable && !rsp_valid && cmd_ready, "R1", "after reset",
          {28'd0, psel, penable, rsp_valid, cmd_ready}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!psel && !penable && cmd_ready, "R2", "idle hold",
            {29'd0, psel, penable, cmd_ready}, 32'h1);
    end

    chained = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (!chained) begin
        present(k);
        #1;
        check(cmd_ready, "R2", "ready before accept", DW'(cmd_ready), 1);
        @(negedge clk);
      end
      run_xfer(k, chained, chain_out);
      chained = chain_out;
    end

    // Reset in the middle of an access phase.
    present(2);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!psel && !penable && !rsp_valid, "R1", "async reset mid access",
          {29'd0, psel, penable, rsp_valid}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!psel && cmd_ready, "R1", "idle after reset release",
          {30'd0, psel, cmd_ready}, 32'h1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule